// File: doc/BRIEF.md
# Predicate Shadow and Squash Unit

This unit sits at the register-fetch stage. For every instruction that reaches the stage, it decides whether the instruction does real work or travels down the execute stages as a NOP. The instruction is never removed from the pipeline. The unit keeps one predicate flag. A compare instruction, or a test that merges two compare results held in registers, writes this flag. Merging two results in this way lets the code form AND or OR of two conditions without a branch.

The unit offers two ways to predicate code. In the first, each instruction carries a 2-bit condition tag. In the second, a shadow instruction opens a window over up to eight following instructions. The shadow instruction supplies a then/else slot mask and a length. The covered instructions carry no condition of their own. A slot marked "then" runs when the predicate captured at the opening is 1. A slot marked "else" runs when that predicate is 0. Once the last slot is used, execution is unconditional again.

Each instruction is used up only when it is valid and not stalled, so bubbles and stalls do not use up slots. A pipeline flush closes any open window.

Top module: `pred_shadow_unit`

## Requirements
- R1: After reset the predicate flag is 0 and `shadow_active` is 0, so an if-true instruction issued right after reset gets `exec_en` = 0.
- R2: Outside a window, `exec_en` follows `cond_tag` in the same cycle. Tag 2'b00 and tag 2'b11 always execute. Tag 2'b01 executes only when the flag is 1. Tag 2'b10 executes only when the flag is 0. `exec_en` is 0 whenever `ins_valid` is 0.
- R3: An instruction with `set_pred` = 1 that executes and advances loads `pred_val` into the flag. The new value applies from the next instruction. A squashed set-predicate instruction leaves the flag unchanged.
- R4: A shadow instruction (`is_shadow` = 1) that executes and advances outside a window opens a window of `min(shadow_len, 8)` slots and sets `shadow_active` the next cycle. A length of 0 opens no window. The shadow instruction itself obeys its own tag.
- R5: Inside a window, the k-th advancing instruction (k from 0) uses `shadow_mask[k]`. A 1 marks a then slot, which executes when the captured predicate is 1. A 0 marks an else slot, which executes when the captured predicate is 0. `cond_tag` is ignored inside a window.
- R6: The predicate is captured when the window opens. A set-predicate instruction inside the window still updates the flag, but the slots that remain keep using the captured value.
- R7: The cycle after the last slot advances, `shadow_active` is 0 and the tag rules of R2 apply again.
- R8: A stalled cycle (`stall` = 1), or a cycle with `ins_valid` = 0, uses no slot and changes no state.
- R9: `flush` forces `exec_en` to 0 in its cycle. It closes any window, so `shadow_active` is 0 the next cycle. It ignores the instruction presented in that cycle and leaves the predicate flag unchanged.
- R10: A shadow instruction inside an open window does not restart or extend the window. It only uses up its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush |
| stall | input | 1 | Register-fetch stage held this cycle |
| ins_valid | input | 1 | An instruction is present at the stage |
| cond_tag | input | 2 | 00/11 unconditional, 01 if-true, 10 if-false |
| set_pred | input | 1 | Instruction is a compare or test that writes the flag |
| pred_val | input | 1 | Value that such an instruction writes |
| is_shadow | input | 1 | Instruction opens a predicate window |
| shadow_mask | input | 8 | Slot kinds, bit k for slot k, 1 = then, 0 = else |
| shadow_len | input | 4 | Number of covered instructions |
| exec_en | output | 1 | Instruction executes (0 = pass on as NOP) |
| shadow_active | output | 1 | A predicate window is open |

## Verification
`exec_en` is combinational from the instruction presented and the registered state, so it is due in the same cycle the instruction is presented. The bench compares it half a period after the inputs change, at the falling edge. `shadow_active` and the predicate flag are registered. Their effect is expected one edge after the advancing instruction that changes them. The reference model therefore updates its queue of pending slot decisions and its flag only after both outputs of the current cycle have been compared. This keeps every expected value aligned to the cycle in which the design must produce it.

// File: rtl/pred_shadow_unit.sv
module pred_shadow_unit #(
  parameter int SLOTS = 8,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             stall,
  input  logic             ins_valid,
  input  logic [1:0]       cond_tag,
  input  logic             set_pred,
  input  logic             pred_val,
  input  logic             is_shadow,
  input  logic [SLOTS-1:0] shadow_mask,
  input  logic [LEN_W-1:0] shadow_len,
  output logic             exec_en,
  output logic             shadow_active
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] left_q;
  logic [SLOTS-1:0] mask_q;
  logic             spred_q;
  logic             pred_q;
  logic             in_sh;
  logic             fire;
  logic             tag_ok;
  logic             open_win;
  logic [CNT_W-1:0] open_len;

  assign in_sh = (left_q != '0);
  assign fire  = ins_valid & ~stall & ~flush;

  always_comb begin
    case (cond_tag)
      2'b01:   tag_ok = pred_q;
      2'b10:   tag_ok = ~pred_q;
      default: tag_ok = 1'b1;
    endcase
  end

  assign exec_en = ins_valid & ~flush &
                   (in_sh ? ~(mask_q[0] ^ spred_q) : tag_ok);

  assign open_len = (int'(shadow_len) > SLOTS) ? CNT_W'(SLOTS) : CNT_W'(shadow_len);
  assign open_win = fire & ~in_sh & is_shadow & exec_en & (shadow_len != '0);

  assign shadow_active = in_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      mask_q  <= '0;
      spred_q <= 1'b0;
      pred_q  <= 1'b0;
    end else if (flush) begin
      left_q <= '0;
    end else if (fire) begin
      if (in_sh) begin
        left_q <= left_q - 1'b1;
        mask_q <= mask_q >> 1;
      end else if (open_win) begin
        left_q  <= open_len;
        mask_q  <= shadow_mask;
        spred_q <= pred_q;
      end
      if (set_pred && exec_en)
        pred_q <= pred_val;
    end
  end

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !shadow_active);

  // R8
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> ($stable(left_q) && $stable(mask_q) && $stable(pred_q)));

  // R4
  window_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_win |=> (shadow_active && left_q == $past(open_len)));

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(left_q) <= SLOTS);

  // R6
  captured_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sh |=> (left_q == '0 || $stable(spred_q)));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sh && fire) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: tb/pred_shadow_unit_bench.sv
module pred_shadow_unit_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, flush, stall, ins_valid, set_pred, pred_val, is_shadow;
  logic [1:0] cond_tag;
  logic [7:0] shadow_mask;
  logic [3:0] shadow_len;
  logic exec_en, shadow_active;

  int checks = 0;
  int fails = 0;
  bit m_pred = 1'b0;
  bit m_q[$];

  always #(CLK_P/2) clk = ~clk;

  pred_shadow_unit u_pred_shadow_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .stall(stall), .ins_valid(ins_valid),
    .cond_tag(cond_tag), .set_pred(set_pred), .pred_val(pred_val), .is_shadow(is_shadow),
    .shadow_mask(shadow_mask), .shadow_len(shadow_len),
    .exec_en(exec_en), .shadow_active(shadow_active));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit st, input bit fl, input bit [1:0] tag,
                     input bit sp, input bit pv, input bit sh, input bit [7:0] mk,
                     input bit [3:0] ln, input string req);
    bit e_en, e_sa, fire, ok;
    int n;
    ins_valid = v; stall = st; flush = fl; cond_tag = tag; set_pred = sp;
    pred_val = pv; is_shadow = sh; shadow_mask = mk; shadow_len = ln;
    @(negedge clk);
    e_sa = (m_q.size() != 0);
    if (m_q.size() != 0) ok = m_q[0];
    else if (tag == 2'b01) ok = m_pred;
    else if (tag == 2'b10) ok = !m_pred;
    else ok = 1'b1;
    e_en = v && !fl && ok;
    chk(req, "exec_en", exec_en, e_en);
    chk(req, "shadow_active", shadow_active, e_sa);
    fire = v && !st && !fl;
    if (fl) m_q.delete();
    else if (fire) begin
      if (m_q.size() != 0) void'(m_q.pop_front());
      else if (sh && e_en && ln != 0) begin
        n = (ln > 8) ? 8 : ln;
        for (int k = 0; k < n; k++) m_q.push_back(mk[k] ? m_pred : !m_pred);
      end
      if (sp && e_en) m_pred = pv;
    end
    @(posedge clk); #1;
  endtask

  task automatic plain(input bit [1:0] tag, input string req);
    cyc(1, 0, 0, tag, 0, 0, 0, 8'h00, 4'd0, req);
  endtask

  task automatic setp(input bit pv, input bit [1:0] tag, input string req);
    cyc(1, 0, 0, tag, 1, pv, 0, 8'h00, 4'd0, req);
  endtask

  task automatic shadow(input bit [7:0] mk, input bit [3:0] ln, input string req);
    cyc(1, 0, 0, 2'b00, 0, 0, 1, mk, ln, req);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush = 0; stall = 0; ins_valid = 0; cond_tag = 0; set_pred = 0;
    pred_val = 0; is_shadow = 0; shadow_mask = 0; shadow_len = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 8'h00, 4'd0, "R1");
    plain(2'b01, "R1");
    // R2: tag encodings with flag 0
    plain(2'b10, "R2");
    plain(2'b00, "R2");
    plain(2'b11, "R2");
    cyc(0, 0, 0, 2'b10, 0, 0, 0, 8'h00, 4'd0, "R2");
    // R3: set flag, then squashed set leaves it
    setp(1, 2'b00, "R3");
    plain(2'b01, "R3");
    plain(2'b10, "R3");
    setp(0, 2'b10, "R3");
    plain(2'b01, "R3");
    // R4/R5: five then, three else, predicate 1, tags ignored
    shadow(8'h1F, 4'd8, "R4");
    for (int i = 0; i < 8; i++) plain(2'b10, "R5");
    // R7: join point
    plain(2'b01, "R7");
    plain(2'b10, "R7");
    // R6: capture 0, change flag inside window
    setp(0, 2'b00, "R6");
    shadow(8'h05, 4'd4, "R6");
    plain(2'b00, "R6");
    setp(1, 2'b00, "R6");
    plain(2'b00, "R6");
    plain(2'b00, "R6");
    plain(2'b01, "R6");
    // R8: stalls and bubbles inside a window
    shadow(8'h02, 4'd3, "R8");
    cyc(1, 1, 0, 2'b00, 0, 0, 0, 8'h00, 4'd0, "R8");
    cyc(0, 0, 0, 2'b00, 0, 0, 0, 8'h00, 4'd0, "R8");
    cyc(1, 1, 0, 2'b00, 1, 0, 0, 8'h00, 4'd0, "R8");
    plain(2'b00, "R8");
    plain(2'b00, "R8");
    plain(2'b00, "R8");
    plain(2'b01, "R8");
    // R9: flush mid-window, flag kept
    shadow(8'hFF, 4'd6, "R9");
    plain(2'b00, "R9");
    cyc(1, 0, 1, 2'b00, 1, 0, 1, 8'h00, 4'd5, "R9");
    plain(2'b01, "R9");
    plain(2'b10, "R9");
    // R4: zero length opens nothing, oversize length clamps to 8
    shadow(8'h00, 4'd0, "R4");
    plain(2'b10, "R4");
    shadow(8'hAA, 4'd12, "R4");
    for (int i = 0; i < 8; i++) plain(2'b00, "R4");
    plain(2'b10, "R4");
    // R4: squashed shadow instruction opens nothing
    cyc(1, 0, 0, 2'b10, 0, 0, 1, 8'hFF, 4'd4, "R4");
    plain(2'b10, "R4");
    // R10: nested shadow only uses its slot
    shadow(8'h03, 4'd2, "R10");
    shadow(8'h00, 4'd8, "R10");
    plain(2'b00, "R10");
    plain(2'b10, "R10");
    // R9: flush outside a window
    cyc(1, 0, 1, 2'b01, 0, 0, 0, 8'h00, 4'd0, "R9");
    plain(2'b01, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule